// File: doc/BRIEF.md
# RX Wake Controller

This block decides when a low-power radio receiver should wake up and start taking data. While enabled it cycles through three phases: a sleep interval with the signal path off, a start-up interval that lets the analog chain settle, and a bit-check interval. During bit-check it measures the time between successive transitions of the demodulated data and compares each measurement with a programmable window. Only a run of consecutive good intervals, which is the signature of a real transmitter preamble, moves the block into the receiving phase. Any bad interval sends it back to sleep.

All timing counts a base tick, a one-cycle enable supplied from outside, so the block runs from a fast system clock while keeping a slow time base. The sleep length is a 5-bit count scaled by a unit of ticks and an optional factor of 8. The interval window is two 6-bit limits, both optionally doubled. A 2-bit field sets how many good intervals are needed. A continuous mode leaves out the sleep phase, so the block goes straight from a failed check back to start-up. `rx_active` tells the analog side when to power the signal path. `rx_start` marks the cycle in which receiving begins. Assembling bytes after that point is done elsewhere.

Top module: `rxwake_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `phase` is 0 (idle), and `rx_active` and `rx_start` are 0 until `run` is raised.
- R2: When `run` is low, the block goes to idle (`phase`=0) on the next clock. When `run` is high in idle, the next clock moves the block to sleep (`phase`=1), or to start-up (`phase`=2) if `cont_mode` is 1.
- R3: Sleep lasts max(T,1) ticks, where T = `sleep_val` × SLEEP_UNIT × (8 if `xsleep` else 1). Clocks without `tick` do not advance the sleep time.
- R4: Start-up lasts max(`startup_len`,1) ticks and is followed by bit-check (`phase`=3). Transitions of `demod` during start-up are not measured.
- R5: `rx_active` is 1 exactly when `phase` is 2, 3 or 4, and is 0 in idle and sleep.
- R6: In bit-check, `demod` is sampled on ticks. The first transition starts the measurement. Each later transition closes an interval, counted in ticks. An interval shorter than LO = `lim_min` × (2 if `xlim` else 1) is a failure.
- R7: If HI = `lim_max` × (2 if `xlim` else 1) ticks pass without a transition, the check fails on that tick. This applies both before the first transition and after any transition.
- R8: When N = 3 × (`chk_sel` + 1) consecutive intervals each lie in [LO, HI], the block enters receiving (`phase`=4) on the tick that closes the last of them. `rx_start` is 1 for exactly that one cycle.
- R9: A failed check moves the block to sleep, or to start-up if `cont_mode` is 1.
- R10: The receiving phase holds for as long as `run` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Base time-step enable, one cycle wide |
| run | input | 1 | Enables the wake cycle; low forces idle |
| cont_mode | input | 1 | 1: skip sleep and retry start-up after a failure |
| demod | input | 1 | Demodulated data, synchronous to clk |
| sleep_val | input | 5 | Sleep length in units of SLEEP_UNIT ticks |
| xsleep | input | 1 | Multiplies the sleep length by 8 |
| startup_len | input | START_W | Start-up length in ticks |
| lim_min | input | 6 | Lower interval limit in ticks |
| lim_max | input | 6 | Upper interval limit in ticks |
| xlim | input | 1 | Doubles both interval limits |
| chk_sel | input | 2 | Selects 3, 6, 9 or 12 required intervals |
| phase | output | 3 | 0 idle, 1 sleep, 2 start-up, 3 bit-check, 4 receiving |
| rx_active | output | 1 | Signal path enable |
| rx_start | output | 1 | One-cycle strobe on entry to receiving |

## Verification
The properties assume that the configuration fields and `cont_mode` change only while `run` is low. They also assume that `demod` and `tick` are already synchronous to `clk`. The stimulus writes every field during an idle gap before raising `run`, and changes `demod` only at falling clock edges. Bit-check trials sweep the transition spacing across both sides of the window, for each multiplier and each required count. Timing is checked to the exact falling edge at which the phase changes. Further runs cover a held-low tick, start-up toggling and continuous mode.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SLEEP = 3'd1,
    PH_START = 3'd2,
    PH_CHECK = 3'd3,
    PH_RECV  = 3'd4
  } phase_e;

  localparam int SLEEP_FW   = 5;
  localparam int LIM_FW     = 6;
  localparam int NSEL_FW    = 2;
  localparam int XSLEEP_MUL = 8;
  localparam int CHK_STEP   = 3;
endpackage

// File: rtl/rxwake_timer.sv
// Tick counter for a single phase; done fires on the tick that completes the length.
module rxwake_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W:0]   elapsed;

  assign elapsed = {1'b0, cnt} + (W+1)'(1);
  assign done    = tick && (elapsed >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxwake_edge_meter.sv
// Measures tick spacing between demod transitions against a scaled window.
module rxwake_edge_meter #(
  parameter int LW = 6,
  parameter int NW = 2,
  parameter int CS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          demod,
  input  logic          arm,
  input  logic [LW-1:0] lim_min,
  input  logic [LW-1:0] lim_max,
  input  logic          xlim,
  input  logic [NW-1:0] nsel,
  output logic          pass_all,
  output logic          fail
);
  localparam int IW = LW + 2;
  localparam int CW = $clog2(CS * (2**NW) + 1);

  logic          smp;
  logic          seen;
  logic [IW-1:0] cnt;
  logic [IW-1:0] elapsed;
  logic [IW-1:0] lo;
  logic [IW-1:0] hi;
  logic [CW-1:0] npass;
  logic [CW-1:0] need_n;
  logic          edge_t;
  logic          too_short;
  logic          too_long;
  logic          good;

  assign lo      = xlim ? (IW'(lim_min) << 1) : IW'(lim_min);
  assign hi      = xlim ? (IW'(lim_max) << 1) : IW'(lim_max);
  assign need_n  = CW'(CS) * (CW'(nsel) + CW'(1));
  assign elapsed = cnt + IW'(1);
  assign edge_t  = tick && (demod != smp);

  assign too_short = edge_t && seen && (elapsed < lo);
  assign too_long  = (tick && !edge_t && (elapsed >= hi)) ||
                     (edge_t && seen && (elapsed > hi));
  assign good      = edge_t && seen && !too_short && (elapsed <= hi);

  assign fail     = arm && (too_short || too_long);
  assign pass_all = arm && good && (npass == need_n - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      smp   <= 1'b0;
      seen  <= 1'b0;
      cnt   <= '0;
      npass <= '0;
    end else begin
      if (tick) smp <= demod;
      if (!arm) begin
        seen  <= 1'b0;
        cnt   <= '0;
        npass <= '0;
      end else if (tick) begin
        if (edge_t) begin
          cnt  <= '0;
          seen <= 1'b1;
          if (good) npass <= npass + CW'(1);
        end else begin
          cnt <= cnt + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rxwake_ctrl.sv
module rxwake_ctrl
  import rxwake_pkg::*;
#(
  parameter int SLEEP_UNIT = 1024,
  parameter int START_W    = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run,
  input  logic               cont_mode,
  input  logic               demod,
  input  logic [SLEEP_FW-1:0] sleep_val,
  input  logic               xsleep,
  input  logic [START_W-1:0] startup_len,
  input  logic [LIM_FW-1:0]  lim_min,
  input  logic [LIM_FW-1:0]  lim_max,
  input  logic               xlim,
  input  logic [NSEL_FW-1:0] chk_sel,
  output logic [2:0]         phase,
  output logic               rx_active,
  output logic               rx_start
);
  localparam int SLEEP_MAX = (2**SLEEP_FW - 1) * SLEEP_UNIT * XSLEEP_MUL;
  localparam int SW        = $clog2(SLEEP_MAX + 1);
  localparam int TW        = (SW > START_W) ? SW : START_W;

  phase_e        state;
  phase_e        nxt;
  logic [TW-1:0] sleep_base;
  logic [TW-1:0] sleep_ticks;
  logic [TW-1:0] t_limit;
  logic          t_clr;
  logic          t_done;
  logic          chk_pass;
  logic          chk_fail;

  assign sleep_base  = TW'(sleep_val) * TW'(SLEEP_UNIT);
  assign sleep_ticks = xsleep ? (sleep_base * TW'(XSLEEP_MUL)) : sleep_base;
  assign t_limit     = (state == PH_SLEEP) ? sleep_ticks : TW'(startup_len);
  assign t_clr       = (nxt != state);

  rxwake_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (t_clr),
    .tick  (tick),
    .limit (t_limit),
    .done  (t_done)
  );

  rxwake_edge_meter #(.LW(LIM_FW), .NW(NSEL_FW), .CS(CHK_STEP)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .demod    (demod),
    .arm      (state == PH_CHECK),
    .lim_min  (lim_min),
    .lim_max  (lim_max),
    .xlim     (xlim),
    .nsel     (chk_sel),
    .pass_all (chk_pass),
    .fail     (chk_fail)
  );

  always_comb begin
    nxt = state;
    if (!run) begin
      nxt = PH_IDLE;
    end else begin
      case (state)
        PH_IDLE:  nxt = cont_mode ? PH_START : PH_SLEEP;
        PH_SLEEP: if (t_done) nxt = PH_START;
        PH_START: if (t_done) nxt = PH_CHECK;
        PH_CHECK: begin
          if (chk_pass)      nxt = PH_RECV;
          else if (chk_fail) nxt = cont_mode ? PH_START : PH_SLEEP;
        end
        PH_RECV:  nxt = PH_RECV;
        default:  nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      rx_active <= 1'b0;
      rx_start  <= 1'b0;
    end else begin
      state     <= nxt;
      rx_active <= (nxt == PH_START) || (nxt == PH_CHECK) || (nxt == PH_RECV);
      rx_start  <= (nxt == PH_RECV) && (state != PH_RECV);
    end
  end

  assign phase = state;
endmodule

// File: rtl/rxwake_ctrl_chk.sv
module rxwake_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       run,
  input logic       cont_mode,
  input logic [2:0] phase,
  input logic       rx_active,
  input logic       rx_start
);
  // R5
  active_map_chk: assert property (@(posedge clk) disable iff (rst)
    rx_active == (phase == 3'd2 || phase == 3'd3 || phase == 3'd4));

  // R2
  run_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == 3'd0 && !rx_active));

  // R3
  sleep_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1 && run && !tick) |=> phase == 3'd1);

  // R8
  start_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_start |-> (phase == 3'd4 && $past(phase) == 3'd3));

  // R10
  recv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4 && run) |=> phase == 3'd4);

  // R9
  fail_to_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && run && !cont_mode) |=> phase != 3'd2);

  // R9
  fail_to_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && run && cont_mode) |=> phase != 3'd1);
endmodule

bind rxwake_ctrl rxwake_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .run       (run),
  .cont_mode (cont_mode),
  .phase     (phase),
  .rx_active (rx_active),
  .rx_start  (rx_start)
);

// File: tb/tb_rxwake_ctrl.sv
`timescale 1ns/1ps
module tb_rxwake_ctrl;
  localparam int UNIT = 4;
  localparam int SWB  = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           tick = 1'b1;
  logic           run = 1'b0;
  logic           cont_mode = 1'b0;
  logic           demod = 1'b0;
  logic [4:0]     sleep_val = '0;
  logic           xsleep = 1'b0;
  logic [SWB-1:0] startup_len = 8'd1;
  logic [5:0]     lim_min = 6'd3;
  logic [5:0]     lim_max = 6'd6;
  logic           xlim = 1'b0;
  logic [1:0]     chk_sel = '0;
  logic [2:0]     phase;
  logic           rx_active;
  logic           rx_start;

  int checks = 0;
  int errors = 0;
  int act_bad = 0;

  always #2.5 clk = ~clk;

  rxwake_ctrl #(.SLEEP_UNIT(UNIT), .START_W(SWB)) dut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .cont_mode(cont_mode),
    .demod(demod), .sleep_val(sleep_val), .xsleep(xsleep),
    .startup_len(startup_len), .lim_min(lim_min), .lim_max(lim_max),
    .xlim(xlim), .chk_sel(chk_sel), .phase(phase), .rx_active(rx_active),
    .rx_start(rx_start)
  );

  // R5 monitor: signal path enable tracks the phase
  always @(negedge clk) begin
    if (!rst && (rx_active != (phase == 3'd2 || phase == 3'd3 || phase == 3'd4)))
      act_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_phase(input logic [2:0] ph);
    for (int i = 0; i < 2000 && phase != ph; i++) @(negedge clk);
  endtask

  task automatic bit_trial(input bit xl, input int sel, input int d, input bit cm);
    int lo, hi, n, k, exp_k;
    logic [2:0] exp_ph;
    go_idle();
    xlim = xl; chk_sel = sel[1:0]; cont_mode = cm;
    sleep_val = 5'd0; startup_len = 8'd2;
    run = 1'b1;
    wait_phase(3'd3);
    k = 0;
    while (phase == 3'd3 && k < 600) begin
      if (k % d == 0) demod = ~demod;
      @(negedge clk);
      k++;
    end
    lo = lim_min * (xl ? 2 : 1);
    hi = lim_max * (xl ? 2 : 1);
    n  = 3 * (sel + 1);
    if (d < lo)      begin exp_k = d + 1;     exp_ph = cm ? 3'd2 : 3'd1; end
    else if (d > hi) begin exp_k = hi + 1;    exp_ph = cm ? 3'd2 : 3'd1; end
    else             begin exp_k = n * d + 1; exp_ph = 3'd4; end
    // R6 R7 R8 decision cycle
    check(k == exp_k, "R6/R7/R8 decision cycle", k, exp_k);
    // R9 R8 resulting phase
    check(phase == exp_ph, "R8/R9 phase after check", phase, exp_ph);
    if (exp_ph == 3'd4) begin
      check(rx_start == 1'b1, "R8 strobe high", rx_start, 1);
      @(negedge clk);
      check(rx_start == 1'b0, "R8 strobe one cycle", rx_start, 0);
      repeat (10) @(negedge clk);
      check(phase == 3'd4, "R10 receive held", phase, 4);
    end else begin
      check(rx_start == 1'b0, "R8 no strobe on fail", rx_start, 0);
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, exp;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(phase == 3'd0, "R1 phase in reset", phase, 0);
    check(rx_active == 1'b0 && rx_start == 1'b0, "R1 outputs in reset", rx_active, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 3'd0 && !rx_active, "R1 idle after reset", phase, 0);

    // R3 sleep length sweep; R2 entry to sleep
    for (int xs = 0; xs < 2; xs++) begin
      for (int sv = 0; sv < 4; sv++) begin
        go_idle();
        sleep_val = sv[4:0]; xsleep = xs[0]; startup_len = 8'd1; cont_mode = 1'b0;
        run = 1'b1;
        @(negedge clk);
        check(phase == 3'd1, "R2 idle to sleep", phase, 1);
        n = 0;
        while (phase == 3'd1 && n < 500) begin n++; @(negedge clk); end
        exp = sv * UNIT * (xs ? 8 : 1);
        if (exp == 0) exp = 1;
        check(n == exp, "R3 sleep ticks", n, exp);
      end
    end

    // R4 start-up length sweep
    for (int s = 0; s < 12; s += 4) begin
      go_idle();
      sleep_val = 5'd0; startup_len = s[SWB-1:0];
      run = 1'b1;
      wait_phase(3'd2);
      n = 0;
      while (phase == 3'd2 && n < 500) begin n++; @(negedge clk); end
      exp = (s == 0) ? 1 : s;
      check(n == exp, "R4 start-up ticks", n, exp);
      check(phase == 3'd3, "R4 start-up to bit-check", phase, 3);
    end

    // R3 sleep frozen without tick
    go_idle();
    sleep_val = 5'd1; xsleep = 1'b0; tick = 1'b0;
    run = 1'b1;
    repeat (20) @(negedge clk);
    check(phase == 3'd1, "R3 no tick keeps sleep", phase, 1);
    tick = 1'b1;
    n = 0;
    while (phase == 3'd1 && n < 500) begin n++; @(negedge clk); end
    check(n == UNIT, "R3 sleep resumes on ticks", n, UNIT);

    // R7 no transition at all, and R4 start-up toggles ignored
    for (int xl = 0; xl < 2; xl++) begin
      go_idle();
      xlim = xl[0]; sleep_val = 5'd0; startup_len = 8'd12; cont_mode = 1'b0;
      run = 1'b1;
      wait_phase(3'd2);
      repeat (5) begin demod = ~demod; @(negedge clk); end
      wait_phase(3'd3);
      n = 0;
      while (phase == 3'd3 && n < 500) begin n++; @(negedge clk); end
      exp = 6 * (xl ? 2 : 1);
      check(n == exp, "R4/R7 timeout without transitions", n, exp);
      check(phase == 3'd1, "R9 timeout returns to sleep", phase, 1);
    end

    // R6 R7 R8 R9 window sweep
    for (int xl = 0; xl < 2; xl++)
      for (int sel = 0; sel < 4; sel++)
        for (int d = 1; d <= 14; d++)
          bit_trial(xl[0], sel, d, 1'b0);

    // R9 continuous mode: entry and failure go to start-up
    go_idle();
    cont_mode = 1'b1;
    run = 1'b1;
    @(negedge clk);
    check(phase == 3'd2, "R2 continuous entry", phase, 2);
    bit_trial(1'b0, 0, 1, 1'b1);
    bit_trial(1'b0, 0, 13, 1'b1);
    bit_trial(1'b1, 1, 8, 1'b1);

    // R2 run low leaves receiving
    run = 1'b0;
    @(negedge clk);
    check(phase == 3'd0 && !rx_active, "R2 run low to idle", phase, 0);

    // R5 aggregate
    check(act_bad == 0, "R5 rx_active mismatches", act_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule